// File: doc/BRIEF.md
# Fast-OR Trigger Bit Serializer

This block turns the 128 strip hit bits of one front-end chip into a compact trigger stream with fixed latency. In each bunch crossing the strips are folded into 32 trigger bits, one per group of four neighbouring strips. The trigger bits, a crossing synchronization tick and two reserved zero bits are then spread over five serial lanes. Each lane runs at eight bit slots per crossing.

The block runs on the fast bit clock, which is eight times the crossing rate. An internal slot counter divides each crossing into slots 0 to 7. Slot 0 of every lane carries a framing bit so that a receiver can find the start of a crossing. Slots 1 to 7 carry seven payload bits. Strips are sampled once per crossing, in its last slot, and the resulting frame is sent during the next crossing.

Top module: `fastor_trig_serializer`

## Requirements
- R1: While reset is held, and in the first seven fast cycles after it is released, every lane outputs 0.
- R2: Trigger bit g is the OR of strips 4g, 4g+1, 4g+2 and 4g+3, for g from 0 to 31.
- R3: In slot 0 of every crossing frame, all five lanes output 1 (framing bit).
- R4: For lanes 0 to 3, lane L in slot k (k = 1..7) outputs trigger bit 7L+k-1. The lowest index is sent first.
- R5: Lane 4 outputs trigger bits 28, 29, 30 and 31 in slots 1 to 4, and outputs 0 in slots 6 and 7 (spare bits).
- R6: Lane 4 slot 5 carries the sync tick. The tick is 1 in the first frame after reset and in every 64th frame after that, and 0 in all other frames.
- R7: The slot counter advances by one on each fast cycle and wraps from 7 to 0. Strips present at the fast edge that ends slot 7 form the frame whose slot 0 appears right after that edge. The first such edge is the eighth edge after reset release.
- R8: Strip values applied during slots 0 to 6 and removed before the last slot's edge have no effect on any lane output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Bit clock, eight periods per crossing |
| rst_n | input | 1 | Synchronous active-low reset |
| strips_i | input | 128 | Strip hit bits of the current crossing |
| lanes_o | output | 5 | Serial lane outputs, one bit slot per cycle |

## Verification
The embedded checks assume that the fast clock is phase-locked to the crossings. They also assume that the strip inputs only need to be valid at the edge that closes slot 7. Bits on the strip inputs at other times may toggle freely. The bench counts fast edges from reset release to track crossing boundaries. It changes the strips only at falling edges. Within each crossing it drives a deliberately corrupt pattern for several slots, and then restores the intended value before the sampling edge. The sweep walks a single hit across all 128 strips and adds all-ones, alternating and pseudo-random patterns. It runs long enough to pass through three sync tick frames.

// File: rtl/fastor_pkg.sv
// Package: shared geometry constants for the fast-OR trigger serializer.
// Assumes: one front-end chip per instance, eight bit slots per crossing.
package fastor_pkg;
    localparam int STRIPS_DEF      = 128;
    localparam int GROUP_DEF       = 4;
    localparam int LANES_DEF       = 5;
    localparam int SLOTS_DEF       = 8;
    localparam int SYNC_PERIOD_DEF = 64;
endpackage

// File: rtl/fastor_reduce.sv
// Module: fastor_reduce
// Folds strip hits into trigger bits, one OR per group of adjacent strips.
// Assumes: STRIPS is a multiple of GROUP. The module is purely combinational.
module fastor_reduce #(
    parameter int STRIPS = fastor_pkg::STRIPS_DEF,
    parameter int GROUP  = fastor_pkg::GROUP_DEF,
    localparam int TRIG  = STRIPS / GROUP
) (
    input  logic [STRIPS-1:0] strips_i,
    output logic [TRIG-1:0]   trig_o
);
    for (genvar g = 0; g < TRIG; g++) begin : g_or
        // one OR gate per strip group
        assign trig_o[g] = |strips_i[g*GROUP +: GROUP];
    end
endmodule

// File: rtl/fastor_frame.sv
// Module: fastor_frame
// Registers one crossing frame: the trigger bits, then the sync tick, then
// zero spare bits, packed by flat index (lane * PAYLOAD + position).
// Assumes: cap_i pulses once per crossing, in its last slot.
module fastor_frame #(
    parameter int TRIG        = 32,
    parameter int LANES       = fastor_pkg::LANES_DEF,
    parameter int PAYLOAD     = fastor_pkg::SLOTS_DEF - 1,
    parameter int SYNC_PERIOD = fastor_pkg::SYNC_PERIOD_DEF,
    localparam int FLAT       = LANES * PAYLOAD,
    localparam int CNT_W      = (SYNC_PERIOD > 1) ? $clog2(SYNC_PERIOD) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_i,
    input  logic [TRIG-1:0] trig_i,
    output logic [FLAT-1:0] frame_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_PERIOD - 1);

    logic [CNT_W-1:0] xing_q;
    logic [FLAT-1:0]  frame_d;
    logic [FLAT-1:0]  frame_q;
    logic             tick_w;

    assign tick_w = (xing_q == '0);

    // crossing counter that sets the sync tick phase
    always_ff @(posedge clk) begin
        if (!rst_n)
            xing_q <= '0;
        else if (cap_i)
            xing_q <= (xing_q == CNT_LAST) ? '0 : xing_q + 1'b1;
    end

    for (genvar f = 0; f < FLAT; f++) begin : g_pack
        if (f < TRIG) begin : g_trig
            assign frame_d[f] = trig_i[f];
        end else if (f == TRIG) begin : g_tick
            assign frame_d[f] = tick_w;
        end else begin : g_spare
            assign frame_d[f] = 1'b0;
        end
    end

    // capture the frame once per crossing
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_q <= '0;
        else if (cap_i)
            frame_q <= frame_d;
    end

    assign frame_o = frame_q;

    // R8: the frame does not change between capture strobes
    assert_frame_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(frame_q));
endmodule

// File: rtl/fastor_lane_ser.sv
// Module: fastor_lane_ser
// Serializes one lane: framing 1 in slot 0, then payload position j in slot j+1.
// Assumes: word_i is updated on the same edge that starts slot 0.
module fastor_lane_ser #(
    parameter int SLOTS   = fastor_pkg::SLOTS_DEF,
    localparam int PAYLOAD = SLOTS - 1,
    localparam int SLOT_W  = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLOT_W-1:0]  slot_i,
    input  logic [PAYLOAD-1:0] word_i,
    output logic               lane_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    logic lane_q;

    // choose the bit for the next slot
    always_ff @(posedge clk) begin
        if (!rst_n)
            lane_q <= 1'b0;
        else if (slot_i == LAST)
            lane_q <= 1'b1;
        else
            lane_q <= word_i[slot_i];
    end

    assign lane_o = lane_q;
endmodule

// File: rtl/fastor_trig_serializer.sv
// Module: fastor_trig_serializer (top)
// Fast-OR trigger serializer: reduces strips, builds a frame per crossing
// and drives it over LANES serial lanes of SLOTS bit slots each.
// Assumes: clk_fast is phase-locked at SLOTS times the crossing rate and
// strips_i is valid at the edge that closes the last slot of a crossing.
module fastor_trig_serializer #(
    parameter int STRIPS      = fastor_pkg::STRIPS_DEF,
    parameter int GROUP       = fastor_pkg::GROUP_DEF,
    parameter int LANES       = fastor_pkg::LANES_DEF,
    parameter int SLOTS       = fastor_pkg::SLOTS_DEF,
    parameter int SYNC_PERIOD = fastor_pkg::SYNC_PERIOD_DEF
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic [STRIPS-1:0] strips_i,
    output logic [LANES-1:0]  lanes_o
);
    localparam int TRIG     = STRIPS / GROUP;
    localparam int PAYLOAD  = SLOTS - 1;
    localparam int FLAT     = LANES * PAYLOAD;
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int SPARE_J  = TRIG + 1 - (LANES - 1) * PAYLOAD;
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] slot_q;
    logic              cap_w;
    logic [TRIG-1:0]   trig_w;
    logic [FLAT-1:0]   frame_w;

    initial begin
        assert_fit_R4: assert (FLAT >= TRIG + 1 && SLOTS == (1 << SLOT_W));
    end

    // bit slot counter inside the crossing
    always_ff @(posedge clk_fast) begin
        if (!rst_n)
            slot_q <= '0;
        else
            slot_q <= slot_q + 1'b1;
    end

    assign cap_w = (slot_q == LAST);

    fastor_reduce #(.STRIPS(STRIPS), .GROUP(GROUP)) u_reduce (
        .strips_i (strips_i),
        .trig_o   (trig_w)
    );

    fastor_frame #(
        .TRIG(TRIG), .LANES(LANES), .PAYLOAD(PAYLOAD), .SYNC_PERIOD(SYNC_PERIOD)
    ) u_frame (
        .clk     (clk_fast),
        .rst_n   (rst_n),
        .cap_i   (cap_w),
        .trig_i  (trig_w),
        .frame_o (frame_w)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        fastor_lane_ser #(.SLOTS(SLOTS)) u_ser (
            .clk    (clk_fast),
            .rst_n  (rst_n),
            .slot_i (slot_q),
            .word_i (frame_w[l*PAYLOAD +: PAYLOAD]),
            .lane_o (lanes_o[l])
        );
    end

    // R7: slot counter steps by one every cycle
    assert_slot_step_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $past(rst_n) |-> slot_q == $past(slot_q) + 1'b1);

    // R3: every lane shows the framing bit in slot 0
    assert_framing_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
        cap_w |=> &lanes_o);

    // R5: spare positions of the last lane stay low
    assert_spare_zero_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (int'(slot_q) >= SPARE_J && int'(slot_q) < PAYLOAD) |=> !lanes_o[LANES-1]);
endmodule

// File: tb/fastor_trig_serializer_bench.sv
`timescale 1ns/1ps
module fastor_trig_serializer_bench;
    localparam int NFRAMES = 140;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] strips = '0;
    logic [4:0]   lanes;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fastor_trig_serializer u_fastor_trig_serializer (
        .clk_fast (clk),
        .rst_n    (rst_n),
        .strips_i (strips),
        .lanes_o  (lanes)
    );

    function automatic logic [127:0] pattern(input int m);
        logic [127:0] p;
        p = '0;
        if (m < 128) p[m] = 1'b1;
        else if (m == 128) p = '1;
        else if (m == 129) p = {32{4'b1010}};
        else if (m == 130) p = '0;
        else begin
            for (int w = 0; w < 4; w++) p[w*32 +: 32] = 32'(m * 32'h9E3779B1 + w * 32'h7F4A7C15);
        end
        return p;
    endfunction

    function automatic logic [31:0] reduce(input logic [127:0] p);
        logic [31:0] t;
        for (int g = 0; g < 32; g++) t[g] = |p[4*g +: 4];
        return t;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(lanes == 5'd0, "R1 lanes in reset", lanes, 0);
        rst_n = 1'b1;
        // edges 1..7 after release: still idle
        for (int i = 1; i <= 7; i++) begin
            @(negedge clk);
            check(lanes == 5'd0, "R1 idle before first frame", lanes, 0);
        end
        strips = pattern(0);
        for (int m = 0; m < NFRAMES; m++) begin
            logic [31:0] t;
            logic        tick;
            t = reduce(pattern(m));
            tick = (m % 64) == 0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                for (int l = 0; l < 5; l++) begin
                    logic e;
                    int   f;
                    if (k == 0) begin
                        check(lanes[l] == 1'b1, $sformatf("R3 R7 framing frame %0d lane %0d", m, l), lanes[l], 1);
                    end else begin
                        f = 7 * l + k - 1;
                        e = (f < 32) ? t[f] : (f == 32) ? tick : 1'b0;
                        if (f == 32)
                            check(lanes[l] == e, $sformatf("R6 tick frame %0d", m), lanes[l], e);
                        else if (l == 4)
                            check(lanes[l] == e, $sformatf("R5 R2 R8 frame %0d slot %0d", m, k), lanes[l], e);
                        else
                            check(lanes[l] == e, $sformatf("R2 R4 R7 R8 frame %0d lane %0d slot %0d", m, l, k), lanes[l], e);
                    end
                end
                if (k == 1) strips = ~pattern(m + 1);
                if (k == 4) strips = pattern(m + 1) ^ {4{32'hDEADBEEF}};
                if (k == 7) strips = pattern(m + 1);
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule